// File: doc/BRIEF.md
# Parallel NOR Flash Bring-Up Probe Sequencer

This block brings a parallel NOR flash out of reset and confirms that a working device is present. A single start pulse sets off a fixed sequence. The block pulses the flash hardware reset line low for a timed interval and then releases it. It then waits through the recovery period that must pass before the chip may be selected. Next it writes the query-mode entry command, reads three identification words and compares their low bytes with the ASCII signature "QRY". Finally it writes a software reset so the flash leaves query mode.

The block does not drive the flash pins itself. Every memory access is handed to a separate bus controller through a request/acknowledge port. A request, together with its address, direction and write data, stays asserted and unchanged until the controller acknowledges it. Read data is taken in the cycle the acknowledge is seen. At the end the block raises `done` and reports the outcome on `pass`. Both stay as they are until the next start pulse, which runs the whole sequence again from the reset pulse.

All timings are given in nanoseconds together with the clock frequency and are converted into cycle counts when the design is elaborated. The defaults are a 10 us reset pulse and a 30 us recovery wait at 50 MHz.

Top module: `nor_probe_seq`

## Requirements
- R1: After system reset `flash_rst_n` is 1 and `bus_req`, `done` and `pass` are 0.
- R2: A start pulse accepted while idle or done drives `flash_rst_n` low for exactly RST_CYC cycles (RST_LOW_NS times CLK_MHZ divided by 1000, rounded up), then back high.
- R3: No bus request is made while `flash_rst_n` is low, nor for exactly RECOVER_CYC cycles after it returns high; the first request follows in the next cycle.
- R4: The first access is a write (`bus_we`=1) of CFI_ENTRY (default 0x0098) to word offset CMD_OFS (default 0x555).
- R5: Then reads (`bus_we`=0) follow at word offsets 0x20, 0x22 and 0x24, in that order. Every request keeps its address, direction and data stable until acknowledged.
- R6: Only bits [7:0] of each read word are compared, against 0x51, 0x52 and 0x59 respectively; bits above bit 7 have no effect on the result.
- R7: With EARLY_EXIT=1 (default), a mismatching read ends the reading: no further read offsets are requested.
- R8: The last access is always a write of SW_RESET (default 0x00F0) to word offset CMD_OFS, whether the check passed or failed, and it completes before `done` rises.
- R9: `done` rises in the cycle after the final acknowledge. `pass` is 1 exactly when all three compared bytes matched. Both hold, with no bus requests, until the next start.
- R10: A start pulse while the sequence is in progress is ignored: the sequence does not restart and no second reset pulse is produced.
- R11: A start pulse while `done` is high clears `done` and `pass` and restarts from the reset pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| start | input | 1 | One-cycle pulse that launches the sequence |
| flash_rst_n | output | 1 | Active-low hardware reset to the flash |
| bus_req | output | 1 | Access request to the bus controller |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | 16-bit word offset of the access |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | One-cycle acknowledge that completes the request |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |
| done | output | 1 | Sequence finished |
| pass | output | 1 | Signature matched (valid while `done`) |

## Verification
The bench runs every combination of right and wrong signature bytes at three acknowledge latencies, and it always drives a nonzero upper byte. A design that compared the whole word would then fail a good device. A design that kept reading after a miss, or that skipped the exit write when the check failed, would show an extra or a missing transaction in the recorded access list. The lengths of the reset pulse and the recovery gap are counted cycle by cycle, so an off-by-one in the timer shows up as a wrong count. A start pulse injected during the reset pulse must not produce a second pulse, and one given while `done` is high must restart the sequence at once.

// File: rtl/nor_probe_pkg.sv
package nor_probe_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RSTLOW,
      ST_RECOVER,
      ST_ENTRY,
      ST_READ,
      ST_EXIT,
      ST_DONE
   } probe_state_e;

   localparam int unsigned NUM_READS   = 3;
   localparam int unsigned READ_BASE   = 32'h20;
   localparam int unsigned READ_STRIDE = 2;

   // expected low byte of identification word idx
   function automatic logic [7:0] sig_byte(input logic [1:0] idx);
      case (idx)
         2'd0:    sig_byte = 8'h51;
         2'd1:    sig_byte = 8'h52;
         default: sig_byte = 8'h59;
      endcase
   endfunction

   // word offset of identification read idx
   function automatic int unsigned read_offset(input logic [1:0] idx);
      read_offset = READ_BASE + READ_STRIDE * int'(idx);
   endfunction

endpackage

// File: rtl/nor_probe_timer.sv
module nor_probe_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/nor_probe_access.sv
module nor_probe_access
   import nor_probe_pkg::*;
#(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned CMD_OFS   = 32'h555,
   parameter int unsigned CFI_ENTRY = 32'h98,
   parameter int unsigned SW_RESET  = 32'hF0
) (
   input  probe_state_e      state,
   input  logic [1:0]        rd_idx,
   output logic              req,
   output logic              we,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata
);
   localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(CMD_OFS);
   localparam logic [DATA_W-1:0] ENTRY_D  = DATA_W'(CFI_ENTRY);
   localparam logic [DATA_W-1:0] EXIT_D   = DATA_W'(SW_RESET);

   always_comb begin
      req   = 1'b0;
      we    = 1'b0;
      addr  = '0;
      wdata = '0;
      unique case (state)
         ST_ENTRY: begin
            req   = 1'b1;
            we    = 1'b1;
            addr  = CMD_ADDR;
            wdata = ENTRY_D;
         end
         ST_READ: begin
            req   = 1'b1;
            addr  = ADDR_W'(read_offset(rd_idx));
         end
         ST_EXIT: begin
            req   = 1'b1;
            we    = 1'b1;
            addr  = CMD_ADDR;
            wdata = EXIT_D;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/nor_probe_sigcheck.sv
module nor_probe_sigcheck
   import nor_probe_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic [1:0]        rd_idx,
   input  logic [DATA_W-1:0] rdata,
   output logic              match
);
   logic [7:0] low_byte;

   generate
      if (DATA_W > 8) begin : g_wide
         logic unused_upper;
         assign unused_upper = ^rdata[DATA_W-1:8];
         assign low_byte     = rdata[7:0];
      end else begin : g_byte
         assign low_byte = rdata[7:0];
      end
   endgenerate

   assign match = (low_byte == sig_byte(rd_idx));
endmodule

// File: rtl/nor_probe_fsm.sv
module nor_probe_fsm
   import nor_probe_pkg::*;
#(
   parameter int unsigned RST_CYC     = 500,
   parameter int unsigned RECOVER_CYC = 1500,
   parameter int unsigned CNT_W       = 11,
   parameter bit          EARLY_EXIT  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             bus_ack,
   input  logic             tmr_expired,
   input  logic             rd_match,
   output probe_state_e     state,
   output logic [1:0]       rd_idx,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             fail
);
   localparam logic [CNT_W-1:0] RST_LOAD = CNT_W'(RST_CYC - 1);
   localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(RECOVER_CYC - 1);
   localparam logic [1:0]       LAST_IDX = 2'(NUM_READS - 1);

   probe_state_e state_q, state_d;
   logic [1:0]   idx_q, idx_d;
   logic         fail_q, fail_d;
   logic         stop_on_miss;

   generate
      if (EARLY_EXIT) begin : g_early
         assign stop_on_miss = !rd_match;
      end else begin : g_full
         assign stop_on_miss = 1'b0;
      end
   endgenerate

   always_comb begin
      state_d  = state_q;
      idx_d    = idx_q;
      fail_d   = fail_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE, ST_DONE: begin
            if (start) begin
               state_d  = ST_RSTLOW;
               idx_d    = '0;
               fail_d   = 1'b0;
               tmr_load = 1'b1;
               tmr_val  = RST_LOAD;
            end
         end
         ST_RSTLOW: begin
            if (tmr_expired) begin
               state_d  = ST_RECOVER;
               tmr_load = 1'b1;
               tmr_val  = REC_LOAD;
            end
         end
         ST_RECOVER: begin
            if (tmr_expired) state_d = ST_ENTRY;
         end
         ST_ENTRY: begin
            if (bus_ack) state_d = ST_READ;
         end
         ST_READ: begin
            if (bus_ack) begin
               if (!rd_match) fail_d = 1'b1;
               if (idx_q == LAST_IDX || stop_on_miss)
                  state_d = ST_EXIT;
               else
                  idx_d = 2'(idx_q + 2'd1);
            end
         end
         ST_EXIT: begin
            if (bus_ack) state_d = ST_DONE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         fail_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
         fail_q  <= fail_d;
      end
   end

   assign state  = state_q;
   assign rd_idx = idx_q;
   assign fail   = fail_q;
endmodule

// File: rtl/nor_probe_seq.sv
module nor_probe_seq
   import nor_probe_pkg::*;
#(
   parameter int unsigned CLK_MHZ     = 50,
   parameter int unsigned RST_LOW_NS  = 10000,
   parameter int unsigned RECOVER_NS  = 30000,
   parameter int unsigned ADDR_W      = 24,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned CMD_OFS     = 32'h555,
   parameter int unsigned CFI_ENTRY   = 32'h98,
   parameter int unsigned SW_RESET    = 32'hF0,
   parameter bit          EARLY_EXIT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              flash_rst_n,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              done,
   output logic              pass
);
   localparam int unsigned RST_CYC     = (RST_LOW_NS * CLK_MHZ + 999) / 1000;
   localparam int unsigned RECOVER_CYC = (RECOVER_NS * CLK_MHZ + 999) / 1000;
   localparam int unsigned MAX_CYC     = (RST_CYC > RECOVER_CYC) ? RST_CYC : RECOVER_CYC;
   localparam int unsigned CNT_W       = $clog2(MAX_CYC + 1);

   generate
      if (RST_CYC < 1) begin : g_bad_rst
         $error("reset pulse must last at least one cycle");
      end
      if (RECOVER_CYC < 1) begin : g_bad_rec
         $error("recovery wait must last at least one cycle");
      end
      if (ADDR_W < 11 || CMD_OFS >= (32'h1 << ADDR_W)) begin : g_bad_addr
         $error("address width too small for command offset");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("data width must hold a byte");
      end
   endgenerate

   probe_state_e     state;
   logic [1:0]       rd_idx;
   logic             tmr_load, tmr_expired, rd_match, fail;
   logic [CNT_W-1:0] tmr_val;

   nor_probe_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   nor_probe_sigcheck #(.DATA_W(DATA_W)) u_sig (
      .rd_idx (rd_idx),
      .rdata  (bus_rdata),
      .match  (rd_match)
   );

   nor_probe_fsm #(
      .RST_CYC     (RST_CYC),
      .RECOVER_CYC (RECOVER_CYC),
      .CNT_W       (CNT_W),
      .EARLY_EXIT  (EARLY_EXIT)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .bus_ack     (bus_ack),
      .tmr_expired (tmr_expired),
      .rd_match    (rd_match),
      .state       (state),
      .rd_idx      (rd_idx),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .fail        (fail)
   );

   nor_probe_access #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CMD_OFS   (CMD_OFS),
      .CFI_ENTRY (CFI_ENTRY),
      .SW_RESET  (SW_RESET)
   ) u_acc (
      .state  (state),
      .rd_idx (rd_idx),
      .req    (bus_req),
      .we     (bus_we),
      .addr   (bus_addr),
      .wdata  (bus_wdata)
   );

   assign flash_rst_n = (state != ST_RSTLOW);
   assign done        = (state == ST_DONE);
   assign pass        = done && !fail;
endmodule

// File: rtl/nor_probe_seq_chk.sv
module nor_probe_seq_chk #(
   parameter int unsigned ADDR_W      = 24,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned RECOVER_CYC = 1500,
   parameter int unsigned CMD_OFS     = 32'h555
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              flash_rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_ack,
   input logic              done,
   input logic              pass
);
   logic [31:0] high_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         high_cnt <= '0;
      else if (!flash_rst_n)
         high_cnt <= '0;
      else if (high_cnt != 32'hFFFF_FFFF)
         high_cnt <= high_cnt + 32'd1;
   end

   // R3: requests only after the full recovery window
   assert_recovery_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (flash_rst_n && high_cnt >= RECOVER_CYC));

   // R5: request fields frozen until acknowledged
   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

   // R4, R8: every write targets the command offset
   assert_write_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we) |-> (bus_addr == ADDR_W'(CMD_OFS)));

   // R9: done and pass hold without start, no requests while done
   assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(pass)));

   assert_quiet_when_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bus_req);

   assert_pass_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pass |-> done);

   // R11: start while done leaves the done state next cycle
   assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> (!done && !flash_rst_n));
endmodule

bind nor_probe_seq nor_probe_seq_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .RECOVER_CYC (RECOVER_CYC),
   .CMD_OFS     (CMD_OFS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .flash_rst_n (flash_rst_n),
   .bus_req     (bus_req),
   .bus_we      (bus_we),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .bus_ack     (bus_ack),
   .done        (done),
   .pass        (pass)
);

// File: tb/nor_probe_seq_test.sv
module nor_probe_seq_test;
   localparam int ADDR_W = 12;
   localparam int DATA_W = 16;
   localparam int LOW_C  = 5;   // 100 ns at 50 MHz
   localparam int REC_C  = 7;   // 140 ns at 50 MHz

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              flash_rst_n, bus_req, bus_we, done, pass;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_wdata, bus_rdata;
   logic              bus_ack;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   nor_probe_seq #(
      .CLK_MHZ(50), .RST_LOW_NS(100), .RECOVER_NS(140),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .flash_rst_n(flash_rst_n),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
      .done(done), .pass(pass)
   );

   // ---------------- bus controller model ----------------
   int lat = 0;
   int wcnt = 0;
   bit ok0 = 1, ok1 = 1, ok2 = 1;
   logic [7:0] hi = 8'hC3;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_ack <= 1'b0;
         wcnt    <= 0;
      end else if (bus_req && !bus_ack) begin
         if (wcnt >= lat) begin
            bus_ack <= 1'b1;
            wcnt    <= 0;
         end else begin
            wcnt <= wcnt + 1;
         end
      end else begin
         bus_ack <= 1'b0;
         wcnt    <= 0;
      end
   end

   always_comb begin
      bus_rdata = {hi, 8'hEE};
      if (bus_addr == 12'h020) bus_rdata = {hi, ok0 ? 8'h51 : 8'h71};
      if (bus_addr == 12'h022) bus_rdata = {hi, ok1 ? 8'h52 : 8'h72};
      if (bus_addr == 12'h024) bus_rdata = {hi, ok2 ? 8'h59 : 8'h79};
   end

   // ---------------- monitor ----------------
   bit mon_en = 0;
   int low_cnt, gap_cnt, falls, ntr, req_in_done;
   bit rose, req_seen, prev_rst;
   logic              tr_we   [8];
   logic [ADDR_W-1:0] tr_addr [8];
   logic [DATA_W-1:0] tr_data [8];

   task automatic mon_clear();
      low_cnt = 0; gap_cnt = 0; falls = 0; ntr = 0; req_in_done = 0;
      rose = 0; req_seen = 0; prev_rst = flash_rst_n;
   endtask

   always @(negedge clk) begin
      if (mon_en) begin
         if (!flash_rst_n) low_cnt++;
         if (prev_rst && !flash_rst_n) falls++;
         if (!prev_rst && flash_rst_n) rose = 1;
         if (bus_req) req_seen = 1;
         if (rose && flash_rst_n && !req_seen) gap_cnt++;
         if (bus_req && bus_ack && ntr < 8) begin
            tr_we[ntr] = bus_we; tr_addr[ntr] = bus_addr; tr_data[ntr] = bus_wdata;
            ntr++;
         end
         if (done && bus_req) req_in_done++;
         prev_rst = flash_rst_n;
      end
   end

   task automatic check(input string req, input bit cond, input int act, input int exp);
      checks++;
      if (!cond) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---------------- watchdog ----------------
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // ---------------- one full probe ----------------
   task automatic run_probe(input bit poke_busy);
      int first_miss, nreads, n;
      bit exp_pass, was_done;
      first_miss = !ok0 ? 0 : (!ok1 ? 1 : (!ok2 ? 2 : 3));
      nreads     = (first_miss < 3) ? first_miss + 1 : 3;
      exp_pass   = (first_miss == 3);
      @(negedge clk);
      was_done = done;
      mon_clear();
      mon_en = 1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (was_done)
         check("R11 restart clears done", !done && !pass && !flash_rst_n,
               {done, pass, flash_rst_n}, 3'b000);
      if (poke_busy) begin
         repeat (2) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      n = 0;
      while (!done && n < 400) begin
         @(negedge clk);
         n++;
      end
      check("R2 reset low cycles", low_cnt == LOW_C, low_cnt, LOW_C);
      check("R3 recovery gap", gap_cnt == REC_C, gap_cnt, REC_C);
      if (poke_busy)
         check("R10 busy start ignored", falls == 1, falls, 1);
      check("R5 transaction count", ntr == nreads + 2, ntr, nreads + 2);
      if (ntr == nreads + 2) begin
         check("R4 entry write", tr_we[0] && tr_addr[0] == 12'h555 && tr_data[0] == 16'h0098,
               {tr_we[0], tr_addr[0], tr_data[0]}, {1'b1, 12'h555, 16'h0098});
         for (int i = 0; i < nreads; i++)
            check("R5 R7 read offset", !tr_we[1+i] && tr_addr[1+i] == ADDR_W'(32'h20 + 2*i),
                  {tr_we[1+i], tr_addr[1+i]}, {1'b0, ADDR_W'(32'h20 + 2*i)});
         check("R8 exit write", tr_we[ntr-1] && tr_addr[ntr-1] == 12'h555 && tr_data[ntr-1] == 16'h00F0,
               {tr_we[ntr-1], tr_addr[ntr-1], tr_data[ntr-1]}, {1'b1, 12'h555, 16'h00F0});
      end
      check("R9 done raised", done, done, 1);
      check("R6 pass value", pass == exp_pass, pass, exp_pass);
      repeat (4) @(negedge clk);
      check("R9 done/pass held", done && pass == exp_pass, {done, pass}, {1'b1, exp_pass});
      check("R9 no request while done", req_in_done == 0 && !bus_req, req_in_done, 0);
      mon_en = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 reset state", flash_rst_n && !bus_req && !done && !pass,
            {flash_rst_n, bus_req, done, pass}, 4'b1000);

      for (int l = 0; l < 3; l++) begin
         for (int p = 0; p < 8; p++) begin
            lat = l;
            ok0 = p[0]; ok1 = p[1]; ok2 = p[2];
            hi  = 8'hC3 ^ 8'(p * 17 + l);
            run_probe((p % 3) == 1);
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule